// File: doc/BRIEF.md
# Capability Mode and Access Controller

This block holds, for each privilege level of a hart, a pair of capability control bits: a mode-enable bit that selects how capability-aware instructions are decoded, and a register-enable bit that gates any use of capability registers, capability CSRs and capability instructions. From those bits, the current privilege and a flag that reports a narrowed XLEN, it produces the effective execution mode (capability, transitional or legacy) and an illegal-instruction request for capability accesses that are not permitted.

The register-enable bit is an access control and takes precedence over the mode-enable bit. Clearing it gives legacy mode whatever the mode-enable bit holds. The machine level has a writable mode-enable bit of its own, so legacy firmware can run right after reset. Its register-enable bit is fixed at 1, because no higher level needs to fence machine capability state. The supervisor and user bits reset to 0, so a lower level cannot reach shared, unbanked capability state until more privileged software grants it. The block has no streaming data path: CSR writes are single-cycle strobes, access checks are combinational, and every pin is a plain control or status signal without a handshake. The decoder and the trap unit are outside this block.

Top module: `cap_mode_ctrl`

## Requirements
- R1: Reset (rst_n low, asynchronous) drives mode_o to 2'b00 and clears the mode-enable and register-enable bits of the supervisor and user levels. After reset a capability access at user or supervisor level raises illegal_o.
- R2: The mode is coded 2'b00 legacy, 2'b01 transitional and 2'b10 capability. Mode-enable 1 with register-enable 1 gives 2'b10. Mode-enable 0 with register-enable 1 gives 2'b01. The value 2'b11 never appears.
- R3: Register-enable 0 at a level gives legacy mode (2'b00) for that level, whatever its mode-enable bit holds.
- R4: The machine register-enable bit reads as 1 at all times and ignores writes. The machine mode-enable bit is writable and resets to 0, so at machine level after reset the mode is transitional and capability accesses are allowed.
- R5: While xlen_narrow_i is 1, both effective bits are 0. The mode becomes legacy and every capability access raises illegal_o.
- R6: illegal_o is 1 in the same cycle exactly when cap_insn_i or cap_csr_i is 1 and the effective register-enable bit of the current level is 0.
- R7: csr_sel_i chooses the written bit pair. The value 0 selects the machine pair, and only its mode-enable bit is written. The value 1 selects the supervisor pair. The value 2 selects the user pair. The value 3 selects nothing. Pairs 0 and 1 take writes only at machine privilege. Pair 2 takes writes at supervisor or machine privilege. A write from any other privilege is ignored. csr_wdata_i bit 0 is mode-enable and bit 1 is register-enable.
- R8: mode_o is registered. The privilege, the XLEN flag and the bits in force at the end of a cycle, including any write in that cycle, appear on mode_o from the next cycle on. Privilege is coded 2'b11 machine, 2'b01 supervisor and 2'b00 user, and the reserved value 2'b10 is treated as user.
- R9: During the cycle of a CSR write, illegal_o and mode_o still reflect the old bit values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_i | input | 2 | Current privilege level |
| xlen_narrow_i | input | 1 | Current XLEN is below the maximum |
| csr_we_i | input | 1 | Write strobe for a control bit pair |
| csr_sel_i | input | 2 | Bit pair selected for the write |
| csr_wdata_i | input | 2 | Write data: bit 0 mode-enable, bit 1 register-enable |
| cap_insn_i | input | 1 | A capability instruction is being issued |
| cap_csr_i | input | 1 | A capability CSR is being accessed |
| mode_o | output | 2 | Effective execution mode, registered |
| illegal_o | output | 1 | Illegal-instruction request, combinational |

## Verification
illegal_o is combinational. The bench drives each cycle's inputs just after the falling edge and compares illegal_o a moment later, before the rising edge, against the model state from before that edge. This is also how the old-value rule for a simultaneous write is checked. mode_o is due one rising edge after its stimulus, so the bench updates its model at that edge and compares mode_o at the following falling edge. The same comparison also shows that a write has not yet changed mode_o during its own cycle.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  localparam int LVL_N  = 3;
  localparam int PRIV_W = 2;
  localparam int SEL_W  = 2;
  localparam int CFG_W  = 2;
  localparam int ME_BIT = 0;
  localparam int RE_BIT = 1;

  localparam int LVL_U = 0;
  localparam int LVL_S = 1;
  localparam int LVL_M = 2;

  localparam logic [PRIV_W-1:0] PRIV_U = 2'b00;
  localparam logic [PRIV_W-1:0] PRIV_S = 2'b01;
  localparam logic [PRIV_W-1:0] PRIV_M = 2'b11;

  localparam logic [SEL_W-1:0] SEL_MACH = 2'd0;
  localparam logic [SEL_W-1:0] SEL_SUP  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_USR  = 2'd2;

  typedef enum logic [1:0] {
    MODE_LEGACY = 2'b00,
    MODE_TRANS  = 2'b01,
    MODE_CAP    = 2'b10
  } cmc_mode_e;

  // Reserved privilege encodings fall to the lowest level.
  function automatic logic [1:0] priv_to_lvl(input logic [PRIV_W-1:0] p);
    case (p)
      PRIV_M:  return 2'd2;
      PRIV_S:  return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic pick_lvl(input logic [LVL_N-1:0] v, input logic [1:0] lvl);
    case (lvl)
      2'd2:    return v[LVL_M];
      2'd1:    return v[LVL_S];
      default: return v[LVL_U];
    endcase
  endfunction

  // Register-enable dominates; a narrowed XLEN clears both bits.
  function automatic cmc_mode_e decode_mode(input logic me, input logic re, input logic narrow);
    if (narrow || !re) return MODE_LEGACY;
    if (me)            return MODE_CAP;
    return MODE_TRANS;
  endfunction
endpackage

// File: rtl/cmc_level_cfg.sv
module cmc_level_cfg
  import cmc_pkg::*;
#(
  parameter bit REG_EN_FIXED = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  output logic             me_d,
  output logic             re_d,
  output logic             re_q
);
  logic me_q;

  assign me_d = wr_en ? wdata[ME_BIT] : me_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) me_q <= 1'b0;
    else        me_q <= me_d;
  end

  generate
    if (REG_EN_FIXED) begin : g_fixed
      logic unused_re_wr;
      assign unused_re_wr = wdata[RE_BIT];
      assign re_d = 1'b1;
      assign re_q = 1'b1;
    end else begin : g_flop
      logic re_r;
      assign re_d = wr_en ? wdata[RE_BIT] : re_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) re_r <= 1'b0;
        else        re_r <= re_d;
      end
      assign re_q = re_r;
    end
  endgenerate
endmodule

// File: rtl/cmc_wr_decode.sv
module cmc_wr_decode
  import cmc_pkg::*;
(
  input  logic [PRIV_W-1:0] priv,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  output logic [LVL_N-1:0]  lvl_we
);
  logic at_m;
  logic at_s_or_m;

  assign at_m      = (priv == PRIV_M);
  assign at_s_or_m = (priv == PRIV_M) || (priv == PRIV_S);

  always_comb begin
    lvl_we = '0;
    if (we) begin
      case (sel)
        SEL_MACH: lvl_we[LVL_M] = at_m;
        SEL_SUP:  lvl_we[LVL_S] = at_m;
        SEL_USR:  lvl_we[LVL_U] = at_s_or_m;
        default:  lvl_we = '0;
      endcase
    end
  end
endmodule

// File: rtl/cmc_access_gate.sv
module cmc_access_gate
  import cmc_pkg::*;
(
  input  logic [PRIV_W-1:0] priv,
  input  logic              narrow,
  input  logic [LVL_N-1:0]  re_q,
  input  logic              cap_insn,
  input  logic              cap_csr,
  output logic              illegal
);
  logic cur_re;

  assign cur_re  = pick_lvl(re_q, priv_to_lvl(priv)) && !narrow;
  assign illegal = (cap_insn || cap_csr) && !cur_re;
endmodule

// File: rtl/cmc_mode_track.sv
module cmc_mode_track
  import cmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRIV_W-1:0] priv,
  input  logic              narrow,
  input  logic [LVL_N-1:0]  me_d,
  input  logic [LVL_N-1:0]  re_d,
  output logic [1:0]        mode
);
  cmc_mode_e mode_q;
  cmc_mode_e mode_n;
  logic [1:0] lvl;

  assign lvl    = priv_to_lvl(priv);
  assign mode_n = decode_mode(pick_lvl(me_d, lvl), pick_lvl(re_d, lvl), narrow);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_LEGACY;
    else        mode_q <= mode_n;
  end

  assign mode = mode_q;
endmodule

// File: rtl/cap_mode_ctrl.sv
module cap_mode_ctrl
  import cmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] priv_i,
  input  logic       xlen_narrow_i,
  input  logic       csr_we_i,
  input  logic [1:0] csr_sel_i,
  input  logic [1:0] csr_wdata_i,
  input  logic       cap_insn_i,
  input  logic       cap_csr_i,
  output logic [1:0] mode_o,
  output logic       illegal_o
);
  logic [LVL_N-1:0] lvl_we;
  logic [LVL_N-1:0] me_d_vec;
  logic [LVL_N-1:0] re_d_vec;
  logic [LVL_N-1:0] re_q_vec;

  cmc_wr_decode u_wr (
    .priv   (priv_i),
    .we     (csr_we_i),
    .sel    (csr_sel_i),
    .lvl_we (lvl_we)
  );

  for (genvar l = 0; l < LVL_N; l++) begin : g_lvl
    cmc_level_cfg #(.REG_EN_FIXED(l == LVL_M)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (lvl_we[l]),
      .wdata (csr_wdata_i),
      .me_d  (me_d_vec[l]),
      .re_d  (re_d_vec[l]),
      .re_q  (re_q_vec[l])
    );
  end

  cmc_access_gate u_gate (
    .priv     (priv_i),
    .narrow   (xlen_narrow_i),
    .re_q     (re_q_vec),
    .cap_insn (cap_insn_i),
    .cap_csr  (cap_csr_i),
    .illegal  (illegal_o)
  );

  cmc_mode_track u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .priv   (priv_i),
    .narrow (xlen_narrow_i),
    .me_d   (me_d_vec),
    .re_d   (re_d_vec),
    .mode   (mode_o)
  );
endmodule

// File: rtl/cap_mode_ctrl_chk.sv
module cap_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] priv_i,
  input logic       xlen_narrow_i,
  input logic       cap_insn_i,
  input logic       cap_csr_i,
  input logic [1:0] mode_o,
  input logic       illegal_o,
  input logic [2:0] re_q_vec
);
  AST_MODE_CODE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'b11); // R2

  AST_NARROW_GIVES_LEGACY: assert property (@(posedge clk) disable iff (!rst_n)
    xlen_narrow_i |=> mode_o == 2'b00); // R5

  AST_NARROW_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (xlen_narrow_i && (cap_insn_i || cap_csr_i)) |-> illegal_o); // R5

  AST_MACH_ACCESS_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == 2'b11 && !xlen_narrow_i) |-> !illegal_o); // R4

  AST_NO_STROBE_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_insn_i || cap_csr_i) |-> !illegal_o); // R6

  AST_USER_CANNOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == 2'b00 || priv_i == 2'b10) |=> $stable(re_q_vec)); // R7

  AST_SUP_CANNOT_WRITE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    priv_i == 2'b01 |=> $stable(re_q_vec[2:1])); // R7
endmodule

bind cap_mode_ctrl cap_mode_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .priv_i        (priv_i),
  .xlen_narrow_i (xlen_narrow_i),
  .cap_insn_i    (cap_insn_i),
  .cap_csr_i     (cap_csr_i),
  .mode_o        (mode_o),
  .illegal_o     (illegal_o),
  .re_q_vec      (re_q_vec)
);

// File: tb/cap_mode_ctrl_tb.sv
`timescale 1ns/1ps
module cap_mode_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] priv_i = 2'b11;
  logic       xlen_narrow_i = 1'b0;
  logic       csr_we_i = 1'b0;
  logic [1:0] csr_sel_i = 2'b00;
  logic [1:0] csr_wdata_i = 2'b00;
  logic       cap_insn_i = 1'b0;
  logic       cap_csr_i = 1'b0;
  logic [1:0] mode_o;
  logic       illegal_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cap_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .priv_i(priv_i), .xlen_narrow_i(xlen_narrow_i),
    .csr_we_i(csr_we_i), .csr_sel_i(csr_sel_i), .csr_wdata_i(csr_wdata_i),
    .cap_insn_i(cap_insn_i), .cap_csr_i(cap_csr_i),
    .mode_o(mode_o), .illegal_o(illegal_o)
  );

  // model state, index 0 user, 1 supervisor, 2 machine
  logic [2:0] m_me, m_re;
  logic [1:0] pend_mode;
  bit         pend_valid = 0;
  string      pend_tag;

  function automatic int lvl_of(input logic [1:0] p);
    if (p == 2'b11) return 2;
    if (p == 2'b01) return 1;
    return 0;
  endfunction

  function automatic logic [1:0] exp_mode(input logic me, input logic re, input logic nar);
    if (nar || !re) return 2'b00;
    return me ? 2'b10 : 2'b01;
  endfunction

  task automatic check(input string tag, input string what, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_me = 3'b000;
    m_re = 3'b100;
    pend_valid = 0;
  endtask

  task automatic step(input logic [1:0] p, input logic nar, input logic we,
                      input logic [1:0] sel, input logic [1:0] wd,
                      input logic ci, input logic cc, input string tag);
    logic exp_ill;
    int   l;
    @(negedge clk);
    if (pend_valid) check(pend_tag, "mode_o", mode_o, pend_mode);
    priv_i = p; xlen_narrow_i = nar; csr_we_i = we; csr_sel_i = sel;
    csr_wdata_i = wd; cap_insn_i = ci; cap_csr_i = cc;
    #1;
    l = lvl_of(p);
    exp_ill = (ci || cc) && !(m_re[l] && !nar);
    check(tag, "illegal_o", {1'b0, illegal_o}, {1'b0, exp_ill});
    @(posedge clk);
    if (we) begin
      case (sel)
        2'd0: if (p == 2'b11) m_me[2] = wd[0];
        2'd1: if (p == 2'b11) begin m_me[1] = wd[0]; m_re[1] = wd[1]; end
        2'd2: if (p == 2'b11 || p == 2'b01) begin m_me[0] = wd[0]; m_re[0] = wd[1]; end
        default: ;
      endcase
    end
    pend_mode  = exp_mode(m_me[l], m_re[l], nar);
    pend_valid = 1;
    pend_tag   = tag;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    csr_we_i = 1'b0; cap_insn_i = 1'b0; cap_csr_i = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    check("R1", "mode_o in reset", mode_o, 2'b00);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: lower levels locked after reset
    step(2'b00, 0, 0, 0, 2'b00, 1, 0, "R1");
    step(2'b01, 0, 0, 0, 2'b00, 0, 1, "R1");
    // R4: machine starts transitional, access allowed
    step(2'b11, 0, 0, 0, 2'b00, 1, 1, "R4");
    step(2'b11, 0, 0, 0, 2'b00, 1, 0, "R4");
    // R9: write machine mode-enable; this cycle still old values
    step(2'b11, 0, 1, 2'd0, 2'b01, 0, 1, "R9");
    step(2'b11, 0, 0, 0, 2'b00, 0, 0, "R2");
    // R4: clearing machine register-enable has no effect
    step(2'b11, 0, 1, 2'd0, 2'b00, 0, 0, "R4");
    step(2'b11, 0, 0, 0, 2'b00, 1, 0, "R4");
    // R7: supervisor cannot write its own pair
    step(2'b01, 0, 1, 2'd1, 2'b11, 1, 0, "R7");
    step(2'b01, 0, 0, 0, 2'b00, 1, 0, "R7");
    step(2'b11, 0, 1, 2'd1, 2'b11, 0, 0, "R7");
    // R2: supervisor now in capability mode
    step(2'b01, 0, 0, 0, 2'b00, 1, 1, "R2");
    // R3: register-enable clear with mode-enable set
    step(2'b11, 0, 1, 2'd1, 2'b01, 0, 0, "R3");
    step(2'b01, 0, 0, 0, 2'b00, 1, 0, "R3");
    step(2'b01, 0, 0, 0, 2'b00, 0, 1, "R3");
    // R5: narrowed XLEN at machine level
    step(2'b11, 1, 0, 0, 2'b00, 1, 0, "R5");
    step(2'b11, 1, 0, 0, 2'b00, 0, 0, "R5");
    // R7: user write ignored, supervisor write to user pair accepted
    step(2'b00, 0, 1, 2'd2, 2'b11, 1, 0, "R7");
    step(2'b01, 0, 1, 2'd2, 2'b10, 0, 0, "R7");
    step(2'b00, 0, 0, 0, 2'b00, 1, 0, "R2");
    // R8: reserved privilege acts as user; select 3 writes nothing
    step(2'b10, 0, 0, 0, 2'b00, 0, 1, "R8");
    step(2'b11, 0, 1, 2'd3, 2'b00, 0, 0, "R7");
    step(2'b00, 0, 0, 0, 2'b00, 1, 0, "R7");
    // random phase
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] p; logic nar, we, ci, cc; logic [1:0] sel, wd; string tag;
      p   = 2'($urandom_range(0, 3));
      nar = ($urandom_range(0, 7) == 0);
      we  = ($urandom_range(0, 2) == 0);
      sel = 2'($urandom_range(0, 3));
      wd  = 2'($urandom_range(0, 3));
      ci  = ($urandom_range(0, 1) == 1);
      cc  = ($urandom_range(0, 3) == 0);
      if (nar)     tag = "R5";
      else if (we) tag = "R9";
      else if (ci || cc) tag = "R6";
      else         tag = "R8";
      step(p, nar, we, sel, wd, ci, cc, tag);
    end
    // R1: reset in mid-run clears lower levels again
    step(2'b11, 0, 1, 2'd1, 2'b11, 0, 0, "R7");
    do_reset();
    step(2'b01, 0, 0, 0, 2'b00, 1, 0, "R1");
    step(2'b00, 0, 0, 0, 2'b00, 0, 1, "R1");
    step(2'b11, 0, 0, 0, 2'b00, 0, 0, "R4");
    step(2'b11, 0, 0, 0, 2'b00, 0, 0, "R4");
    @(negedge clk);
    if (pend_valid) check(pend_tag, "mode_o", mode_o, pend_mode);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule